// File: doc/BRIEF.md
# Video Pixel Clock Enable Generator

This block derives a one-cycle pixel enable pulse from one of three source tick streams: a crystal tick and two PLL ticks. The selected tick stream first goes through a predivider with a ratio of 2, 2.5 or 3. The resulting ticks then feed an integer divider that can be set from 2 to 127. With the half-integer ratio, the predivider spaces its ticks 2 and 3 source ticks apart in turn, so the average ratio comes out exact.

One 15-bit control word sets up the block. A separate enable input turns the output on and off. Software picks the field values for a target pixel rate. Each output pulse comes after ((code+3) × div) / 2 source ticks on average, where code is the predivider code and div is the integer divider.

Top module: `vidclk_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pix_en` is low and `cfg_err` is high. The captured configuration resets to all zeros, which is an invalid setting.
- R2: The control word has the following fields:
  - `ctrl[6:0]` is the integer divider.
  - `ctrl[9:8]` is the predivider code.
  - `ctrl[13]` chooses between the PLLs.
  - `ctrl[14]` chooses between the crystal and the PLLs.
  
  With `ctrl[14]`=0, the crystal tick is counted. With `ctrl[14]`=1 and `ctrl[13]`=0, the PLL1 tick is counted. With `ctrl[14]`=1 and `ctrl[13]`=1, the PLL2 tick is counted.
- R3: Predivider code 1 gives one predivided tick every 2 source ticks. Code 3 gives one every 3 source ticks. An output pulse follows every div predivided ticks.
- R4: Predivider code 2 spaces predivided ticks 2, 3, 2, 3 … source ticks apart, starting with 2. The alternation carries across output pulses. With div=3, successive pulse intervals are 7, 8, 7, 8 source ticks.
- R5: `pix_en` is never high in two consecutive cycles.
- R6: A divider value below 2 or a predivider code of 0 drives `cfg_err` high. While `cfg_err` is high, `pix_en` stays low.
- R7: While `enable` is low, `pix_en` stays low and both counters are held at zero. Suppose `enable` is raised with a stable control word and a source that ticks every cycle. Then the first pulse appears in the cycle after the P-th clock edge, where P is the full period in source ticks.
- R8: A change to any bit of `ctrl` clears both counters in the cycle it is seen, and no pulse is produced in that cycle. With a source that ticks every cycle, the first pulse of the new setting arrives P+1 cycles after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_xtal | input | 1 | Crystal source tick, one cycle per source edge |
| tick_pll1 | input | 1 | PLL1 source tick |
| tick_pll2 | input | 1 | PLL2 source tick |
| ctrl | input | 15 | Divider, predivider code and source select fields |
| enable | input | 1 | Output enable; low clears the counters |
| pix_en | output | 1 | One-cycle pixel enable pulse |
| cfg_err | output | 1 | High while the captured configuration is invalid |

## Verification
The hardest behaviour to reach from the ports is the ÷2.5 phase carrying across output pulses. With an even product of interval pairs it cannot be seen, so the bench uses div=3. The phase then shows up only as alternating pulse intervals of 7 and 8.

A reconfiguration made while the block is running must restart both counters with no runt pulse. The bench covers this by changing the control word mid-period and timing the first new pulse to the exact cycle.

Source selection is made visible by giving the three tick inputs different rates (every cycle, every second cycle and every third cycle). The steady pulse interval then shows which source is being counted.

// File: rtl/vidclk_gen.sv
module vidclk_gen #(
  parameter int DIV_W  = 7,
  parameter int CODE_W = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_xtal,
  input  logic        tick_pll1,
  input  logic        tick_pll2,
  input  logic [14:0] ctrl,
  input  logic        enable,
  output logic        pix_en,
  output logic        cfg_err
);
  localparam int CODE_LO  = 8;
  localparam int PSEL_BIT = 13;
  localparam int ESEL_BIT = 14;

  logic [14:0]       cfg_q;
  logic [1:0]        pre_cnt;
  logic              half;
  logic [DIV_W-1:0]  div_cnt;
  logic [1:0]        pre_last;

  wire [DIV_W-1:0]  div_v  = cfg_q[DIV_W-1:0];
  wire [CODE_W-1:0] code   = cfg_q[CODE_LO +: CODE_W];
  wire              cfg_ok = (div_v >= DIV_W'(2)) && (code != '0);
  wire              cfg_chg = (ctrl != cfg_q);
  wire              run    = enable && cfg_ok && !cfg_chg;
  wire              src    = cfg_q[ESEL_BIT] ? (cfg_q[PSEL_BIT] ? tick_pll2 : tick_pll1)
                                             : tick_xtal;

  always_comb begin
    case (code)
      CODE_W'(1): pre_last = 2'd1;
      CODE_W'(2): pre_last = half ? 2'd2 : 2'd1;
      CODE_W'(3): pre_last = 2'd2;
      default:    pre_last = 2'd1;
    endcase
  end

  wire pre_tick = run && src && (pre_cnt == pre_last);
  wire wrap     = pre_tick && (div_cnt == div_v - DIV_W'(1));

  assign cfg_err = !cfg_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      pre_cnt <= '0;
      half    <= 1'b0;
      div_cnt <= '0;
      pix_en  <= 1'b0;
    end else begin
      cfg_q  <= ctrl;
      pix_en <= wrap;
      if (!run) begin
        pre_cnt <= '0;
        half    <= 1'b0;
        div_cnt <= '0;
      end else if (src) begin
        if (pre_tick) begin
          pre_cnt <= '0;
          if (code == CODE_W'(2)) half <= ~half;
          div_cnt <= wrap ? '0 : div_cnt + DIV_W'(1);
        end else begin
          pre_cnt <= pre_cnt + 2'd1;
        end
      end
    end
  end

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> !pix_en);

  // R6
  err_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !pix_en);

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pix_en);

  // R8
  reconfig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl != cfg_q) |=> (!pix_en && pre_cnt == 2'd0 && div_cnt == '0));

  // R4
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= 2'd2);

  // R3
  div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> (div_cnt < div_v));
endmodule

// File: tb/vidclk_gen_tb_top.sv
module vidclk_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_on = 1'b1;
  logic [14:0] ctrl = '0;
  logic enable = 1'b0;
  logic tick_xtal, tick_pll1, tick_pll2, pix_en, cfg_err;
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick_xtal = xtal_on;
  assign tick_pll1 = (cyc % 2) == 0;
  assign tick_pll2 = (cyc % 3) == 0;

  vidclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tick_xtal(tick_xtal), .tick_pll1(tick_pll1),
    .tick_pll2(tick_pll2), .ctrl(ctrl), .enable(enable),
    .pix_en(pix_en), .cfg_err(cfg_err)
  );

  function automatic logic [14:0] mk(input int esel, input int psel, input int code, input int dv);
    logic [14:0] w;
    w = '0;
    w[14] = 1'(esel);
    w[13] = 1'(psel);
    w[9:8] = 2'(code);
    w[6:0] = 7'(dv);
    return w;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int n, input int limit);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (pix_en) return;
    end
    n = -1;
  endtask

  task automatic start(input logic [14:0] w);
    @(negedge clk);
    enable = 1'b0;
    ctrl = w;
    repeat (3) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 pix_en in reset", pix_en, 0);
    chk("R1 cfg_err in reset", cfg_err, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pix_en after reset", pix_en, 0);
  endtask

  task automatic t_fixed;
    int n;
    start(mk(0, 0, 1, 2));
    measure(n, 100); chk("R7 first pulse div2/2", n, 4);
    measure(n, 100); chk("R3 interval div2/2", n, 4);
    measure(n, 100); chk("R3 interval div2/2 again", n, 4);
    start(mk(0, 0, 3, 5));
    measure(n, 100); chk("R7 first pulse div3/5", n, 15);
    measure(n, 100); chk("R3 interval div3/5", n, 15);
  endtask

  task automatic t_half;
    int n;
    start(mk(0, 0, 2, 2));
    measure(n, 100); chk("R4 first pulse div2.5/2", n, 5);
    measure(n, 100); chk("R4 interval div2.5/2", n, 5);
    start(mk(0, 0, 2, 3));
    measure(n, 100); chk("R4 first interval div2.5/3", n, 7);
    measure(n, 100); chk("R4 second interval div2.5/3", n, 8);
    measure(n, 100); chk("R4 third interval div2.5/3", n, 7);
    measure(n, 100); chk("R4 fourth interval div2.5/3", n, 8);
  endtask

  task automatic t_sources;
    int n;
    start(mk(1, 0, 1, 2));
    measure(n, 200);
    measure(n, 200); chk("R2 PLL1 steady interval", n, 8);
    start(mk(1, 1, 1, 2));
    measure(n, 200);
    measure(n, 200); chk("R2 PLL2 steady interval", n, 12);
    start(mk(0, 1, 1, 2));
    measure(n, 200);
    measure(n, 200); chk("R2 crystal with PSEL set", n, 4);
  endtask

  task automatic t_maxdiv;
    int n;
    start(mk(0, 0, 3, 127));
    measure(n, 1000); chk("R3 first pulse max divider", n, 381);
    measure(n, 1000); chk("R3 interval max divider", n, 381);
  endtask

  task automatic t_pulse;
    start(mk(0, 0, 1, 2));
    @(posedge pix_en);
    @(negedge clk);
    @(negedge clk);
    chk("R5 pulse one cycle wide", pix_en, 0);
  endtask

  task automatic t_invalid;
    int n;
    start(mk(0, 0, 1, 1));
    @(negedge clk); chk("R6 err div1", cfg_err, 1);
    measure(n, 60); chk("R6 no pulse div1", n, -1);
    start(mk(0, 0, 1, 0));
    @(negedge clk); chk("R6 err div0", cfg_err, 1);
    start(mk(0, 0, 0, 5));
    @(negedge clk); chk("R6 err code0", cfg_err, 1);
    measure(n, 60); chk("R6 no pulse code0", n, -1);
    start(mk(0, 0, 1, 2));
    chk("R6 err clear when valid", cfg_err, 0);
  endtask

  task automatic t_enable;
    int n;
    start(mk(0, 0, 1, 3));
    measure(n, 100);
    repeat (2) @(negedge clk);
    enable = 1'b0;
    measure(n, 60); chk("R7 no pulse while disabled", n, -1);
    enable = 1'b1;
    measure(n, 100); chk("R7 full period after enable", n, 6);
  endtask

  task automatic t_reconfig;
    int n;
    start(mk(0, 0, 1, 2));
    measure(n, 100);
    @(negedge clk);
    ctrl = mk(0, 0, 3, 4);
    measure(n, 100); chk("R8 first pulse after reconfig", n, 13);
    measure(n, 100); chk("R8 interval after reconfig", n, 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_fixed();
    t_half();
    t_sources();
    t_maxdiv();
    t_pulse();
    t_invalid();
    t_enable();
    t_reconfig();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule